// File: doc/BRIEF.md
# Synchronous Master/Slave Serial Port

This block is an 8-bit clocked serial port for a small microcontroller. One shift register does both jobs. It turns a byte written by software into a bit stream on the serial data output, and at the same time it collects the bits arriving on the serial data input. Software reads the received byte back from the same register once the transfer is done. The port can run as a master, where it drives the serial clock itself. In that case the clock comes from one of three sources: a low-speed oscillator tick, a programmable-timer underflow pulse, or the system clock. The port can also run as a slave, where an external master drives the serial clock.

The four pins of the port also serve as general-purpose I/O. Out of reset they behave as plain GPIO. A serial-enable bit switches them over to the serial functions. The serial data output has its own output-enable bit, so the pin can stay in high impedance while the port is in serial mode. In slave mode a ready pin tells the external master that a transfer has been armed and is waiting. At the end of every transfer an interrupt request flag is raised, and it stays set until software clears it.

Register map (8-bit, `regAddr`):

| Address | Name | Fields |
|---|---|---|
| 0 | control | bit0 serial enable, bit1 data-out enable, bits3:2 clock source (0 oscillator tick, 1 timer underflow, 2 system clock, 3 external/slave) |
| 1 | data | shift register (write loads it, read returns it) |
| 2 | status | bit0 busy, bit1 interrupt flag (write 1 clears), bits7:4 raw pin levels |
| 3 | gpio | bits3:0 output levels, bits7:4 output enables |

Top module: `sync_serial_port`

## Requirements
- R1: After reset every pin has its output enable at 0, `irq` is 0, and status bits 1:0 read 0.
- R2: With serial enable at 0, `pinOut` equals gpio bits 3:0 and `pinOe` equals gpio bits 7:4, and status bits 7:4 read the raw `pinIn` levels.
- R3: With serial enable at 1, pin 0 is always an input. Pin 2 is a driven output in the three master sources and an input for source 3. Pin 3 stays GPIO in master mode and is the driven ready output for source 3.
- R4: With serial enable at 1, pin 1 drives only while the data-out enable bit (control bit1) is 1, and it is high impedance otherwise.
- R5: In master mode the serial clock on pin 2 idles high and makes exactly 8 low/high cycles per transfer. It toggles once per tick of the selected source: `oscTick` for source 0, `timerUf` for source 1, every system clock for source 2. It does not move while idle.
- R6: Bits leave MSB first. Pin 1 changes on a falling serial-clock edge and pin 0 is sampled on a rising edge. After the transfer, the data register reads the 8 received bits, with the first one received as the MSB.
- R7: The eighth rising edge sets the interrupt flag (`irq`, status bit1). It stays set until a status write with bit1 = 1, and a status write with bit1 = 0 leaves it set.
- R8: In slave mode the port shifts on edges of the external clock on pin 2. The ready pin 3 goes to 1 after a start and returns to 0 at the first falling edge of the external clock.
- R9: A start trigger is ignored while serial enable is 0: busy stays 0 and no clock appears.
- R10: Status bit0 reads 1 from an accepted start until the eighth rising edge. A data-register write while busy does not alter the byte being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| startTrig | input | 1 | One-cycle transfer start pulse |
| oscTick | input | 1 | Low-speed oscillator tick (source 0) |
| timerUf | input | 1 | Timer underflow pulse (source 1) |
| irq | output | 1 | Transfer-complete interrupt request |
| pinIn | input | 4 | Pin input levels |
| pinOut | output | 4 | Pin output levels |
| pinOe | output | 4 | Pin output enables (0 = high impedance) |

## Verification
A bit counter in the wrong state shows up directly at the ports. The number of serial-clock cycles on pin 2 comes out other than eight, and the interrupt flag rises early or late. Both are visible in the same transfer. A wrong busy or ready state changes the status read or pin 3 within a cycle of the start or of the first falling clock edge. A shift register that shifts the wrong way or loses a bit gives a wrong byte on pin 1 during the transfer, and a wrong received byte in the data register as soon as the transfer ends.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int REG_W  = 8;
  localparam int PIN_N  = 4;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_DATA   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_GPIO   = 2'd3;

  typedef enum logic [1:0] {
    SRC_OSC   = 2'd0,
    SRC_TIMER = 2'd1,
    SRC_SYS   = 2'd2,
    SRC_EXT   = 2'd3
  } clkSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture parallel write data
    logic shiftOut;  // falling serial edge: present next bit
    logic sample;    // rising serial edge: take input bit
  } sspStrobe_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  input  logic [WIDTH-1:0] resetVal,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) stage[s] <= resetVal;
      else if (s == 0) stage[s] <= asyncIn;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWdata,
  input  logic             startTrig,
  input  logic             oscTick,
  input  logic             timerUf,
  input  logic             extSclk,
  output logic             serEn,
  output logic             outEn,
  output clkSrc_t          clkSel,
  output logic             slaveMode,
  output logic             busy,
  output logic             sclkOut,
  output logic             readyOut,
  output logic             irqFlag,
  output logic [PIN_N-1:0] gpioOut,
  output logic [PIN_N-1:0] gpioDir,
  output sspStrobe_t       strobe
);
  logic [CNT_W-1:0] bitCnt;
  logic             extPrev;
  logic             tick;
  logic             fallEv;
  logic             riseEv;
  logic             startOk;
  logic             lastBit;
  logic             ctrlWr;
  logic             statusWr;
  logic             gpioWr;

  assign slaveMode = (clkSel == SRC_EXT);
  assign ctrlWr    = regWe && (regAddr == ADDR_CTRL);
  assign statusWr  = regWe && (regAddr == ADDR_STATUS);
  assign gpioWr    = regWe && (regAddr == ADDR_GPIO);
  assign startOk   = startTrig && serEn && !busy;
  assign lastBit   = (bitCnt == CNT_W'(DATA_W - 1));

  always_comb begin
    unique case (clkSel)
      SRC_OSC:   tick = oscTick;
      SRC_TIMER: tick = timerUf;
      SRC_SYS:   tick = 1'b1;
      default:   tick = 1'b0;
    endcase
  end

  always_comb begin
    if (slaveMode) begin
      fallEv = busy && extPrev && !extSclk;
      riseEv = busy && !extPrev && extSclk;
    end else begin
      fallEv = busy && tick && sclkOut;
      riseEv = busy && tick && !sclkOut;
    end
  end

  always_comb begin
    strobe.load     = regWe && (regAddr == ADDR_DATA) && !busy;
    strobe.shiftOut = fallEv;
    strobe.sample   = riseEv;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serEn    <= 1'b0;
      outEn    <= 1'b0;
      clkSel   <= SRC_OSC;
      gpioOut  <= '0;
      gpioDir  <= '0;
      busy     <= 1'b0;
      bitCnt   <= '0;
      sclkOut  <= 1'b1;
      readyOut <= 1'b0;
      irqFlag  <= 1'b0;
      extPrev  <= 1'b1;
    end else begin
      extPrev <= extSclk;
      if (ctrlWr) begin
        serEn  <= regWdata[0];
        outEn  <= regWdata[1];
        clkSel <= clkSrc_t'(regWdata[3:2]);
      end
      if (gpioWr) begin
        gpioOut <= regWdata[PIN_N-1:0];
        gpioDir <= regWdata[REG_W-1:PIN_N];
      end
      if (startOk) begin
        busy     <= 1'b1;
        bitCnt   <= '0;
        sclkOut  <= 1'b1;
        readyOut <= slaveMode;
      end else begin
        if (fallEv) readyOut <= 1'b0;
        if (!slaveMode && (fallEv || riseEv)) sclkOut <= ~sclkOut;
        if (riseEv) begin
          bitCnt <= bitCnt + 1'b1;
          if (lastBit) busy <= 1'b0;
        end
      end
      if (riseEv && lastBit) irqFlag <= 1'b1;
      else if (statusWr && regWdata[1]) irqFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sspStrobe_t        strobe,
  input  logic [DATA_W-1:0] loadData,
  input  logic              sinBit,
  output logic [DATA_W-1:0] shiftData,
  output logic              soutBit
);
  logic [DATA_W-1:0] shiftReg;
  logic              soutReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      soutReg  <= 1'b0;
    end else begin
      if (strobe.load) shiftReg <= loadData;
      else if (strobe.sample) shiftReg <= {shiftReg[DATA_W-2:0], sinBit};
      if (strobe.shiftOut) soutReg <= shiftReg[DATA_W-1];
    end
  end

  assign shiftData = shiftReg;
  assign soutBit   = soutReg;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  input  logic             startTrig,
  input  logic             oscTick,
  input  logic             timerUf,
  output logic             irq,
  input  logic [3:0]       pinIn,
  output logic [3:0]       pinOut,
  output logic [3:0]       pinOe
);
  logic             serEn;
  logic             outEn;
  clkSrc_t          clkSel;
  logic             slaveMode;
  logic             busy;
  logic             sclkOut;
  logic             readyOut;
  logic             irqFlag;
  logic [PIN_N-1:0] gpioOut;
  logic [PIN_N-1:0] gpioDir;
  sspStrobe_t       strobe;
  logic [1:0]       syncPins;
  logic             sinBit;
  logic [DATA_W-1:0] shiftData;
  logic             soutBit;

  ssp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({pinIn[2], pinIn[0]}),
    .resetVal(2'b10),
    .syncOut(syncPins)
  );

  ssp_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .startTrig(startTrig), .oscTick(oscTick), .timerUf(timerUf),
    .extSclk(syncPins[1]),
    .serEn(serEn), .outEn(outEn), .clkSel(clkSel), .slaveMode(slaveMode),
    .busy(busy), .sclkOut(sclkOut), .readyOut(readyOut), .irqFlag(irqFlag),
    .gpioOut(gpioOut), .gpioDir(gpioDir), .strobe(strobe)
  );

  assign sinBit = slaveMode ? syncPins[0] : pinIn[0];

  ssp_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .loadData(regWdata[DATA_W-1:0]), .sinBit(sinBit),
    .shiftData(shiftData), .soutBit(soutBit)
  );

  assign irq = irqFlag;

  always_comb begin
    pinOut = gpioOut;
    pinOe  = gpioDir;
    if (serEn) begin
      pinOut[0] = 1'b0;
      pinOe[0]  = 1'b0;
      pinOut[1] = soutBit;
      pinOe[1]  = outEn;
      pinOut[2] = slaveMode ? 1'b0 : sclkOut;
      pinOe[2]  = !slaveMode;
      if (slaveMode) begin
        pinOut[3] = readyOut;
        pinOe[3]  = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:   regRdata = {4'b0, clkSel, outEn, serEn};
      ADDR_DATA:   regRdata = REG_W'(shiftData);
      ADDR_STATUS: regRdata = {pinIn, 2'b0, irqFlag, busy};
      default:     regRdata = {gpioDir, gpioOut};
    endcase
  end
endmodule

// File: rtl/sync_serial_port_checker.sv
module sync_serial_port_checker (
  input logic       clk,
  input logic       rstN,
  input logic       serEn,
  input logic       outEn,
  input logic       slaveMode,
  input logic       busy,
  input logic       irq,
  input logic       regWe,
  input logic [1:0] regAddr,
  input logic [7:0] regWdata,
  input logic [3:0] pinOut,
  input logic [3:0] pinOe
);
  a_r3_sin_is_input: assert property (@(posedge clk) disable iff (!rstN)
    serEn |-> !pinOe[0]);

  a_r3_ready_only_slave: assert property (@(posedge clk) disable iff (!rstN)
    (serEn && !slaveMode) |-> (pinOe[2] && !(pinOe[3] && !pinOe[2])));

  a_r4_sout_hiz: assert property (@(posedge clk) disable iff (!rstN)
    (serEn && !outEn) |-> !pinOe[1]);

  a_r5_sclk_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    (serEn && !slaveMode && !busy) |-> pinOut[2]);

  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(regWe && regAddr == 2'd2 && regWdata[1])) |=> irq);

  a_r10_busy_ends_with_irq: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irq);
endmodule

bind sync_serial_port sync_serial_port_checker uChecker (
  .clk(clk), .rstN(rstN), .serEn(serEn), .outEn(outEn),
  .slaveMode(slaveMode), .busy(busy), .irq(irq),
  .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       startTrig = 1'b0;
  logic       oscTick = 1'b0;
  logic       timerUf = 1'b0;
  logic       irq;
  logic [3:0] pinIn = 4'b0100;
  logic [3:0] pinOut;
  logic [3:0] pinOe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sync_serial_port uut (.*);

  always #5 clk = ~clk;

  int oscCnt = 0;
  int tmrCnt = 0;
  always @(negedge clk) begin
    oscCnt <= (oscCnt == 3) ? 0 : oscCnt + 1;
    tmrCnt <= (tmrCnt == 6) ? 0 : tmrCnt + 1;
    oscTick <= (oscCnt == 3);
    timerUf <= (tmrCnt == 6);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    startTrig = 1'b1;
    @(negedge clk);
    startTrig = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] st;
    check(pinOe == 4'b0, "R1 pinOe", pinOe, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    rdReg(2'd2, st);
    check(st[1:0] == 2'b0, "R1 status", st[1:0], 0);
  endtask

  task automatic testGpio();
    logic [7:0] st;
    wrReg(2'd3, 8'h53);
    @(negedge clk);
    check(pinOe == 4'b0101, "R2 gpio oe", pinOe, 4'b0101);
    check(pinOut == 4'b0011, "R2 gpio out", pinOut, 4'b0011);
    pinIn = 4'b1101;
    rdReg(2'd2, st);
    check(st[7:4] == 4'b1101, "R2 pin read", st[7:4], 4'b1101);
    pinIn = 4'b0100;
  endtask

  task automatic testMapping();
    wrReg(2'd3, 8'h88);
    wrReg(2'd0, 8'h01);
    @(negedge clk);
    check(pinOe == 4'b1100, "R3 master oe", pinOe, 4'b1100);
    check(pinOut[3] == 1'b1, "R3 pin3 gpio", pinOut[3], 1);
    check(pinOut[2] == 1'b1, "R5 sclk idle", pinOut[2], 1);
    check(pinOe[1] == 1'b0, "R4 sout hiz", pinOe[1], 0);
    wrReg(2'd0, 8'h03);
    @(negedge clk);
    check(pinOe == 4'b1110, "R4 sout enabled", pinOe, 4'b1110);
    wrReg(2'd0, 8'h0F);
    @(negedge clk);
    check(pinOe == 4'b1010, "R3 slave oe", pinOe, 4'b1010);
    check(pinOut[3] == 1'b0, "R8 ready idle", pinOut[3], 0);
  endtask

  task automatic testStartIgnored();
    logic [7:0] st;
    wrReg(2'd0, 8'h08);
    pulseStart();
    repeat (4) @(negedge clk);
    rdReg(2'd2, st);
    check(st[0] == 1'b0, "R9 start ignored", st[0], 0);
    check(irq == 1'b0, "R9 no irq", irq, 0);
  endtask

  task automatic masterXfer(input logic [1:0] sel, input logic [7:0] tx,
                            input logic [7:0] slv, input bit midWrite,
                            input int minCyc, input int maxCyc);
    logic [7:0] got = 8'd0;
    logic [7:0] st;
    int falls = 0;
    int rises = 0;
    int cyc = 0;
    bit prev = 1'b1;
    bit busySeen = 1'b0;
    wrReg(2'd0, {4'b0, sel, 2'b11});
    wrReg(2'd1, tx);
    pinIn[0] = slv[7];
    pulseStart();
    while (rises < 8 && cyc < 1000) begin
      @(negedge clk);
      regWe = 1'b0;
      cyc++;
      if (cyc == 1) begin
        regAddr = 2'd2;
        #1 busySeen = regRdata[0];
      end
      if (prev && !pinOut[2]) begin
        falls++;
        got = {got[6:0], pinOut[1]};
        pinIn[0] = slv[8 - falls];
        if (midWrite && falls == 3) begin
          regWe = 1'b1; regAddr = 2'd1; regWdata = 8'h00;
        end
      end
      if (!prev && pinOut[2]) rises++;
      prev = pinOut[2];
    end
    regWe = 1'b0;
    check(busySeen, "R10 busy during transfer", busySeen, 1);
    check(falls == 8 && rises == 8, "R5 eight clocks", falls, 8);
    check(cyc >= minCyc && cyc <= maxCyc, "R5 clock source rate", cyc, minCyc);
    check(got == tx, midWrite ? "R10 write while busy" : "R6 msb first out", got, tx);
    @(negedge clk);
    rdReg(2'd1, st);
    check(st == slv, "R6 received byte", st, slv);
    rdReg(2'd2, st);
    check(st[1:0] == 2'b10, "R7 irq set busy clear", st[1:0], 2'b10);
    check(irq == 1'b1, "R7 irq pin", irq, 1);
  endtask

  task automatic testIrqClear();
    wrReg(2'd2, 8'h00);
    @(negedge clk);
    check(irq == 1'b1, "R7 write0 keeps", irq, 1);
    wrReg(2'd2, 8'h02);
    @(negedge clk);
    check(irq == 1'b0, "R7 clear", irq, 0);
  endtask

  task automatic testIdleClock();
    int moves = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pinOut[2] != 1'b1) moves++;
    end
    check(moves == 0, "R5 no clock idle", moves, 0);
  endtask

  task automatic testSlave(input logic [7:0] tx, input logic [7:0] slv);
    logic [7:0] got = 8'd0;
    logic [7:0] st;
    pinIn[2] = 1'b1;
    wrReg(2'd0, 8'h0F);
    wrReg(2'd1, tx);
    repeat (4) @(negedge clk);
    pulseStart();
    @(negedge clk);
    check(pinOut[3] == 1'b1 && pinOe[3], "R8 ready after start", pinOut[3], 1);
    for (int i = 0; i < 8; i++) begin
      pinIn[2] = 1'b0;
      repeat (6) @(negedge clk);
      got = {got[6:0], pinOut[1]};
      if (i == 0) check(pinOut[3] == 1'b0, "R8 ready drops", pinOut[3], 0);
      pinIn[0] = slv[7 - i];
      repeat (6) @(negedge clk);
      pinIn[2] = 1'b1;
      repeat (6) @(negedge clk);
    end
    check(got == tx, "R8 slave out", got, tx);
    rdReg(2'd1, st);
    check(st == slv, "R8 slave in", st, slv);
    rdReg(2'd2, st);
    check(st[1:0] == 2'b10, "R8 slave done", st[1:0], 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGpio();
    testMapping();
    testStartIgnored();
    masterXfer(2'd2, 8'hA5, 8'h3C, 1'b0, 15, 18);
    testIrqClear();
    testIdleClock();
    masterXfer(2'd1, 8'h81, 8'h7E, 1'b0, 100, 125);
    testIrqClear();
    masterXfer(2'd0, 8'hC3, 8'h18, 1'b1, 55, 72);
    testIrqClear();
    testSlave(8'h5A, 8'hE1);
    testIrqClear();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule